// File: doc/BRIEF.md
# Comma-Based Byte Boundary Aligner

The aligner sits right after a 1:20 deserializer. Each clock it receives a 20-bit word that holds two 10-bit line symbols, and the symbol edges can fall at any bit position. It joins the current word to the word before it. It then scans all twenty start positions for a plus-polarity comma pattern and a minus-polarity comma pattern. Each pattern has a compare mask, and mask bits that are zero are don't-care. When a comma is found, a barrel selector moves the output window so that the comma starts on a symbol edge.

Two enable inputs, one per polarity, decide which commas may move the window. A separate lock flag reports that the current window has been confirmed by an on-edge comma. A one-cycle pulse marks each move of the window. With the `DOUBLE` parameter set, the only search pattern is a 20-bit pattern: a plus comma followed directly by a minus comma. In that mode both enables act together.

The control has two states:
- `ST_HUNT`: not locked.
- `ST_LOCKED`: locked.

The transitions are:
- **confirm** (`ST_HUNT`→`ST_LOCKED`): an enabled comma lands on the current edge.
- **slip** (`ST_LOCKED`→`ST_HUNT`): a comma that cannot be acted on arrives off-edge. Either its polarity is disabled, or both enables are low. The window stays where it is.
- **shift** (any state→`ST_HUNT`): an enabled comma arrives off-edge. The window moves to the comma and `realign` pulses.
- **hold** (stay): no comma arrives, or a comma arrives on the current edge without any change being needed.

Top module: `comma_aligner`

## Requirements
- R1: After reset, `lock_ofs` is 0, `aligned` is 0, `realign` is 0 and `aligned_word` is 0.
- R2: A comma is detected only on the bits whose compare-mask bit is 1. Bit j of a pattern or mask refers to the j-th bit received. Flipping a masked-off bit still gives a detection. Flipping a compared bit removes the detection.
- R3: A plus comma can move the window or set `aligned` only while `plus_en` is 1. A minus comma can do so only while `minus_en` is 1.
- R4: Consider an enabled comma that starts at window position k, where k ranges over 0..19 and position 0 is the oldest bit of the previous word. If k mod 10 equals `lock_ofs`, the comma is on-edge. After that edge `aligned` is 1, and `lock_ofs` and `realign` stay unchanged.
- R5: An enabled off-edge comma sets `lock_ofs` to k mod 10 on the same edge. It drives `realign` high for that single cycle and drives `aligned` low.
- R6: An off-edge comma that is not enabled clears `aligned` and leaves `lock_ofs` unchanged.
- R7: While both enables are low, `lock_ofs` holds its value and `realign` stays 0. A locked state survives on-edge commas.
- R8: With `DOUBLE`=1, detection needs a plus comma followed directly by a minus comma. The window moves only when both enables are high. A lone plus comma, or a pair with extra bits between the two commas, has no effect.
- R9: If several enabled commas start in the same window, the lowest start position decides.
- R10: `aligned_word` equals the 20 window bits that start at the `lock_ofs` value valid after the same edge. Output bit 0 is the oldest of these bits, and the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | 2*SYM_W | Unaligned deserializer word, bit 0 received first |
| plus_en | input | 1 | Allows plus commas to move the window |
| minus_en | input | 1 | Allows minus commas to move the window |
| aligned_word | output | 2*SYM_W | Symbol-aligned output word |
| lock_ofs | output | $clog2(SYM_W) | Current window offset |
| aligned | output | 1 | Lock flag |
| realign | output | 1 | One-cycle pulse on each window move |

## Verification
The bench builds two copies of the block with 10-bit symbols.

The first copy uses single-comma mode with a compare mask of 0x07F. With that mask the three last-received bits of each comma are don't-care, so the masking rule can be exercised directly. The short effective pattern also makes random data hit commas often, which brings frequent slips, shifts and simultaneous matches within reach.

The second copy uses `DOUBLE`=1 with a full mask. It is fed planted pairs, some adjacent and some with a gap, so that the 20-bit joined pattern and the paired enable rule are both exercised.

// File: rtl/comma_aligner_pkg.sv
package comma_aligner_pkg;
    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } align_state_e;
endpackage

// File: rtl/ca_match.sv
// Masked pattern compare at every start position of the search window.
module ca_match #(
    parameter int NPOS  = 20,
    parameter int PAT_W = 10,
    parameter int WIN_W = NPOS + PAT_W - 1,
    parameter logic [PAT_W-1:0] PAT = '0,
    parameter logic [PAT_W-1:0] MSK = '1
) (
    input  logic [WIN_W-1:0] win,
    output logic [NPOS-1:0]  hit
);
    for (genvar k = 0; k < NPOS; k++) begin : g_pos
        assign hit[k] = ((win[k +: PAT_W] ^ PAT) & MSK) == '0;
    end
endmodule

// File: rtl/ca_first.sv
// Lowest set request wins.
module ca_first #(
    parameter int N  = 20,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ca_shift.sv
// Offset-selected slice of the window.
module ca_shift #(
    parameter int NSEL  = 10,
    parameter int OUT_W = 20,
    parameter int SW    = $clog2(NSEL),
    parameter int WIN_W = NSEL - 1 + OUT_W
) (
    input  logic [WIN_W-1:0] win,
    input  logic [SW-1:0]    sel,
    output logic [OUT_W-1:0] dout
);
    always_comb begin
        dout = '0;
        for (int s = 0; s < NSEL; s++) begin
            if (sel == SW'(s)) dout = win[s +: OUT_W];
        end
    end
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
    import comma_aligner_pkg::*;
#(
    parameter int SYM_W = 10,
    parameter logic [SYM_W-1:0] PLUS_PAT  = 10'h17C,
    parameter logic [SYM_W-1:0] MINUS_PAT = 10'h283,
    parameter logic [SYM_W-1:0] CMP_MASK  = 10'h3FF,
    parameter bit DOUBLE = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2*SYM_W-1:0]         rx_word,
    input  logic                       plus_en,
    input  logic                       minus_en,
    output logic [2*SYM_W-1:0]         aligned_word,
    output logic [$clog2(SYM_W)-1:0]   lock_ofs,
    output logic                       aligned,
    output logic                       realign
);
    localparam int WORD_W = 2 * SYM_W;
    localparam int CW     = DOUBLE ? 2 * SYM_W : SYM_W;
    localparam int USE_W  = WORD_W - 1 + CW;
    localparam int SH_W   = SYM_W - 1 + WORD_W;
    localparam int POS_W  = $clog2(WORD_W);
    localparam int OFF_W  = $clog2(SYM_W);

    logic [WORD_W-1:0] prev_q;
    logic [USE_W-1:0]  win;
    logic [WORD_W-1:0] raw_hit, en_hit, on_edge;
    logic              en_found, raw_off;
    logic [POS_W-1:0]  first_k, k_red;
    logic [OFF_W-1:0]  ofs_q, ofs_nxt, ofs_cand;
    align_state_e      st_q, st_nxt;
    logic              re_nxt;
    logic [WORD_W-1:0] shifted;

    assign win = {rx_word[USE_W-WORD_W-1:0], prev_q};

    if (DOUBLE) begin : g_double
        logic [WORD_W-1:0] d_hit;
        ca_match #(.NPOS(WORD_W), .PAT_W(CW), .WIN_W(USE_W),
                   .PAT({MINUS_PAT, PLUS_PAT}), .MSK({CMP_MASK, CMP_MASK}))
            u_dbl (.win(win), .hit(d_hit));
        assign raw_hit = d_hit;
        assign en_hit  = (plus_en && minus_en) ? d_hit : '0;
    end else begin : g_single
        logic [WORD_W-1:0] p_hit, m_hit;
        ca_match #(.NPOS(WORD_W), .PAT_W(CW), .WIN_W(USE_W),
                   .PAT(PLUS_PAT), .MSK(CMP_MASK))
            u_plus (.win(win), .hit(p_hit));
        ca_match #(.NPOS(WORD_W), .PAT_W(CW), .WIN_W(USE_W),
                   .PAT(MINUS_PAT), .MSK(CMP_MASK))
            u_minus (.win(win), .hit(m_hit));
        assign raw_hit = p_hit | m_hit;
        assign en_hit  = (plus_en ? p_hit : '0) | (minus_en ? m_hit : '0);
    end

    ca_first #(.N(WORD_W), .IW(POS_W))
        u_first (.req(en_hit), .found(en_found), .idx(first_k));

    assign k_red    = (first_k >= POS_W'(SYM_W)) ? first_k - POS_W'(SYM_W) : first_k;
    assign ofs_cand = OFF_W'(k_red);

    always_comb begin
        for (int k = 0; k < WORD_W; k++) begin
            on_edge[k] = (k == int'(ofs_q)) || (k == int'(ofs_q) + SYM_W);
        end
    end
    assign raw_off = |(raw_hit & ~on_edge);

    // next-state and output decisions
    always_comb begin
        st_nxt  = st_q;
        ofs_nxt = ofs_q;
        re_nxt  = 1'b0;
        unique case (st_q)
            ST_HUNT: begin
                if (en_found) begin
                    if (ofs_cand == ofs_q) begin
                        st_nxt = ST_LOCKED;          // confirm
                    end else begin
                        ofs_nxt = ofs_cand;          // shift
                        re_nxt  = 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                if (en_found) begin
                    if (ofs_cand != ofs_q) begin
                        st_nxt  = ST_HUNT;           // shift
                        ofs_nxt = ofs_cand;
                        re_nxt  = 1'b1;
                    end
                end else if (raw_off) begin
                    st_nxt = ST_HUNT;                // slip
                end
            end
        endcase
    end

    ca_shift #(.NSEL(SYM_W), .OUT_W(WORD_W), .SW(OFF_W), .WIN_W(SH_W))
        u_shift (.win(win[SH_W-1:0]), .sel(ofs_nxt), .dout(shifted));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_HUNT;
            ofs_q        <= '0;
            realign      <= 1'b0;
            prev_q       <= '0;
            aligned_word <= '0;
        end else begin
            st_q         <= st_nxt;
            ofs_q        <= ofs_nxt;
            realign      <= re_nxt;
            prev_q       <= rx_word;
            aligned_word <= shifted;
        end
    end

    assign aligned  = (st_q == ST_LOCKED);
    assign lock_ofs = ofs_q;

    // R5: a window move never leaves the lock flag high
    assert_realign_unlocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        realign |-> !aligned);
    // R5: a pulse always coincides with a new offset
    assert_realign_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        realign |-> (lock_ofs != $past(lock_ofs)));
    // R7: with both enables low nothing moves
    assert_frozen_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!plus_en && !minus_en) |=> ($stable(lock_ofs) && !realign));
    // R3: lock is only gained through an enabled comma
    assert_lock_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(plus_en || minus_en));
    if (DOUBLE) begin : g_pair_chk
        // R8: paired enables in double mode
        assert_enable_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
            plus_en == minus_en);
    end
endmodule

// File: tb/comma_aligner_bench.sv
`timescale 1ns/1ps
module comma_aligner_bench;
    localparam logic [9:0]  PLUS  = 10'h17C;
    localparam logic [9:0]  MINUS = 10'h283;
    localparam logic [9:0]  A_MSK = 10'h07F;
    localparam logic [19:0] ALT   = 20'h55555;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [19:0] a_din = ALT, b_din = ALT;
    logic a_pe = 1'b1, a_me = 1'b1, b_en = 1'b1;
    logic [19:0] a_dout, b_dout;
    logic [3:0]  a_ofs, b_ofs;
    logic a_al, a_re, b_al, b_re;

    comma_aligner #(.PLUS_PAT(PLUS), .MINUS_PAT(MINUS), .CMP_MASK(A_MSK), .DOUBLE(1'b0))
        u_comma_aligner (.clk(clk), .rst_n(rst_n), .rx_word(a_din), .plus_en(a_pe),
                         .minus_en(a_me), .aligned_word(a_dout), .lock_ofs(a_ofs),
                         .aligned(a_al), .realign(a_re));
    comma_aligner #(.PLUS_PAT(PLUS), .MINUS_PAT(MINUS), .CMP_MASK(10'h3FF), .DOUBLE(1'b1))
        u_comma_aligner_dbl (.clk(clk), .rst_n(rst_n), .rx_word(b_din), .plus_en(b_en),
                             .minus_en(b_en), .aligned_word(b_dout), .lock_ofs(b_ofs),
                             .aligned(b_al), .realign(b_re));

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [19:0] m_prev [2];
    int          m_off  [2];
    bit          m_lock [2];
    bit          e_re   [2];
    logic [19:0] e_dout [2];

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit pat_hit(logic [39:0] w, int k, logic [19:0] pat, int len,
                                   logic [9:0] msk);
        for (int j = 0; j < len; j++)
            if (msk[j % 10] && (w[k + j] !== pat[j])) return 1'b0;
        return 1'b1;
    endfunction

    // reference behaviour from the requirements
    task automatic model_step(input int ln, input logic [19:0] d, input bit pe, input bit me);
        logic [39:0] w;
        bit fe, rawoff, hp, hm, raw, en;
        int ke;
        w = {d, m_prev[ln]};
        fe = 0; rawoff = 0; ke = 0;
        for (int k = 0; k < 20; k++) begin
            if (ln == 1) begin
                raw = pat_hit(w, k, {MINUS, PLUS}, 20, 10'h3FF);
                en  = raw && pe && me;
            end else begin
                hp  = pat_hit(w, k, {10'h0, PLUS}, 10, A_MSK);
                hm  = pat_hit(w, k, {10'h0, MINUS}, 10, A_MSK);
                raw = hp || hm;
                en  = (hp && pe) || (hm && me);
            end
            if (en && !fe) begin fe = 1; ke = k; end
            if (raw && (k % 10) != m_off[ln]) rawoff = 1;
        end
        e_re[ln] = 0;
        if (fe) begin
            if ((ke % 10) == m_off[ln]) m_lock[ln] = 1;
            else begin m_off[ln] = ke % 10; m_lock[ln] = 0; e_re[ln] = 1; end
        end else if (rawoff) m_lock[ln] = 0;
        e_dout[ln] = w[m_off[ln] +: 20];
        m_prev[ln] = d;
    endtask

    task automatic tick(input logic [19:0] ad, input logic [19:0] bd);
        a_din = ad; b_din = bd;
        model_step(0, ad, a_pe, a_me);
        model_step(1, bd, b_en, b_en);
        @(negedge clk);
        chk("R5 offset lane A", a_ofs, m_off[0]);
        chk("R4 lock lane A", a_al, m_lock[0]);
        chk("R5 pulse lane A", a_re, e_re[0]);
        chk("R10 data lane A", a_dout, e_dout[0]);
        chk("R8 offset lane B", b_ofs, m_off[1]);
        chk("R8 lock lane B", b_al, m_lock[1]);
        chk("R8 pulse lane B", b_re, e_re[1]);
        chk("R10 data lane B", b_dout, e_dout[1]);
    endtask

    function automatic logic [39:0] plant(logic [39:0] s, int pos, logic [19:0] pat, int len);
        for (int j = 0; j < len; j++) s[pos + j] = pat[j];
        return s;
    endfunction

    task automatic send_a(input logic [39:0] s);
        tick(s[19:0], ALT);
        tick(s[39:20], ALT);
    endtask

    task automatic send_b(input logic [39:0] s);
        tick(ALT, s[19:0]);
        tick(ALT, s[39:20]);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [39:0] s;
        void'($urandom(32'd2024));
        for (int i = 0; i < 2; i++) begin m_prev[i] = '0; m_off[i] = 0; m_lock[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset offset", a_ofs, 0);
        chk("R1 reset lock", a_al, 0);
        chk("R1 reset pulse", a_re, 0);
        chk("R1 reset data", a_dout, 0);

        // R5: off-edge enabled plus comma
        send_a(plant({ALT, ALT}, 3, {10'h0, PLUS}, 10));
        chk("R5 shift offset", a_ofs, 3);
        chk("R5 shift pulse", a_re, 1);
        chk("R5 shift unlocks", a_al, 0);
        chk("R10 comma in symbol 0", a_dout[9:0], PLUS);
        tick(ALT, ALT);
        chk("R5 pulse lasts one cycle", a_re, 0);
        // R4: on-edge comma confirms
        send_a(plant({ALT, ALT}, 13, {10'h0, PLUS}, 10));
        chk("R4 confirm lock", a_al, 1);
        chk("R4 confirm offset", a_ofs, 3);
        chk("R10 comma in symbol 1", a_dout[19:10], PLUS);
        // R6: disabled minus comma off-edge
        a_me = 0;
        send_a(plant({ALT, ALT}, 7, {10'h0, MINUS}, 10));
        chk("R6 slip unlocks", a_al, 0);
        chk("R6 slip keeps offset", a_ofs, 3);
        chk("R3 disabled polarity no pulse", a_re, 0);
        a_me = 1;
        send_a(plant({ALT, ALT}, 3, {10'h0, PLUS}, 10));
        chk("R4 relock", a_al, 1);
        // R7: both enables low
        a_pe = 0; a_me = 0;
        send_a(plant({ALT, ALT}, 13, {10'h0, PLUS}, 10));
        chk("R7 lock held", a_al, 1);
        send_a(plant({ALT, ALT}, 5, {10'h0, PLUS}, 10));
        chk("R7 offset frozen", a_ofs, 3);
        chk("R7 no pulse", a_re, 0);
        chk("R6 frozen slip unlocks", a_al, 0);
        // R3: polarity enables
        a_me = 1;
        send_a(plant({ALT, ALT}, 5, {10'h0, PLUS}, 10));
        chk("R3 plus ignored", a_ofs, 3);
        send_a(plant({ALT, ALT}, 5, {10'h0, MINUS}, 10));
        chk("R3 minus aligns", a_ofs, 5);
        chk("R3 minus pulse", a_re, 1);
        // R2: mask
        a_pe = 1;
        send_a(plant({ALT, ALT}, 8, {10'h0, PLUS ^ 10'h380}, 10));
        chk("R2 masked bits ignored", a_ofs, 8);
        send_a(plant({ALT, ALT}, 4, {10'h0, PLUS ^ 10'h008}, 10));
        chk("R2 compared bit matters", a_ofs, 8);
        chk("R2 no pulse", a_re, 0);
        // R9: lowest start wins
        s = plant({ALT, ALT}, 2, {10'h0, PLUS}, 10);
        s = plant(s, 14, {10'h0, PLUS}, 10);
        send_a(s);
        chk("R9 lowest offset", a_ofs, 2);

        // R8: double mode
        send_b(plant({ALT, ALT}, 4, {10'h0, PLUS}, 10));
        chk("R8 lone plus ignored", b_ofs, 0);
        chk("R8 lone plus no pulse", b_re, 0);
        send_b(plant({ALT, ALT}, 4, {MINUS, PLUS}, 20));
        chk("R8 pair aligns", b_ofs, 4);
        chk("R8 pair pulse", b_re, 1);
        s = plant({ALT, ALT}, 6, {10'h0, PLUS}, 10);
        s = plant(s, 17, {10'h0, MINUS}, 10);
        send_b(s);
        chk("R8 gapped pair ignored", b_ofs, 4);
        send_b(plant({ALT, ALT}, 14, {MINUS, PLUS}, 20));
        chk("R8 pair confirms", b_al, 1);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic [39:0] sa, sb;
            int p;
            a_pe = ($urandom_range(0, 3) != 0);
            a_me = ($urandom_range(0, 3) != 0);
            b_en = ($urandom_range(0, 4) != 0);
            sa = {$urandom(), $urandom()};
            sb = {$urandom(), $urandom()};
            if ($urandom_range(0, 1) != 0)
                sa = plant(sa, $urandom_range(0, 19), $urandom_range(0, 1) ? {10'h0, PLUS} : {10'h0, MINUS}, 10);
            if ($urandom_range(0, 2) != 0) begin
                p = $urandom_range(0, 18);
                if ($urandom_range(0, 3) == 0) begin
                    sb = plant(sb, p, {10'h0, PLUS}, 10);
                    sb = plant(sb, p + 11, {10'h0, MINUS}, 10);
                end else sb = plant(sb, p, {MINUS, PLUS}, 20);
            end
            tick(sa[19:0], sb[19:0]);
            tick(sa[39:20], sb[39:20]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule